// File: doc/BRIEF.md
# Centronics Parallel-Port Byte Receiver

This block is the peripheral side of a parallel printer-style port. The host places a byte on the data lines and pulls the active-low strobe. The receiver synchronizes the strobe and latches the byte on its falling edge. It then holds BUSY high, does the receive action, and answers with an active-low ACK pulse. The ACK width and the position of BUSY relative to ACK are taken from configuration inputs.

Each byte is compared with an eight-entry table of control characters. A byte that matches no entry is written to the current receive buffer. A match on an entry whose reject flag is clear writes the byte and then closes the buffer. A match on an entry whose reject flag is set keeps the byte out of the buffer: it goes to a side register and raises an event. A buffer also closes when its byte count reaches a programmed maximum, so one data stream can fill several buffers. The buffer is a simple downstream interface: a ready level in, and a write strobe with a running count and a close strobe out.

If no buffer is ready when a byte arrives, the receiver keeps BUSY high and holds the byte until a buffer becomes ready. It reports this with a one-cycle event. Three event pulses (buffer done, control character rejected, busy stall) are masked into a single interrupt line.

The control FSM has four states. IDLE: BUSY low, waiting for a strobe fall. STALL: a byte is held and no buffer is ready. STORE: one cycle in which the byte is written, closed or rejected. ACK: the ACK pulse is driven. The transitions are:
- IDLE to STORE on a strobe fall when a buffer is ready.
- IDLE to STALL on a strobe fall when no buffer is ready.
- STALL to STORE when a buffer becomes ready.
- STORE to ACK always.
- ACK to IDLE when the ACK length has elapsed.

Top module: `parport_rx`

## Requirements
- R1: After reset, busy is 0, ack_n is 1, and wr_en, buf_close, ev_ctl, ev_buf, ev_busy and irq are all 0.
- R2: data_in is latched at the synchronized falling edge of strobe_n. busy is high from the third rising clock edge after strobe_n falls.
- R3: For every byte, ack_n goes low for exactly cfg_ack_len clock cycles, starting one cycle after the byte is acted on. A cfg_ack_len of 0 gives a 1-cycle pulse.
- R4: With cfg_busy_early=1, busy is low for the whole ACK pulse. With cfg_busy_early=0, busy is high for the whole ACK pulse and falls in the cycle ack_n returns high.
- R5: Table entry i occupies ctl_table[10*i+9:10*i]. Bit 10*i+9 is the valid flag, bit 10*i+8 is the reject flag, and bits 10*i+7:10*i hold the character. Invalid entries never match. When several valid entries match, the one with the lowest index decides.
- R6: A byte that matches no entry gives one wr_en pulse, with wr_data equal to the byte and wr_count equal to the number of bytes now in the buffer, this one included.
- R7: A byte that matches a valid entry with the reject flag clear is written as in R6, and buf_close pulses in the same cycle. The next write starts at a count of 1.
- R8: A byte that matches a valid entry with the reject flag set is not written. rccr takes the byte, ev_ctl pulses for one cycle, and the buffer count is unchanged.
- R9: A written byte whose wr_count equals max_len (max_len of 1 or more) closes the buffer, with buf_close pulsing alongside wr_en.
- R10: ev_buf pulses in exactly the cycles in which buf_close pulses.
- R11: If buf_ready is 0 when a byte is latched, ev_busy pulses once. While buf_ready stays 0, busy stays high and ack_n stays high. The byte is handled once buf_ready is 1.
- R12: irq is high in a cycle exactly when an enabled event pulses. irq_en bit 0 enables ev_buf, bit 1 enables ev_ctl, and bit 2 enables ev_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| data_in | input | 8 | Host data lines |
| busy | output | 1 | BUSY handshake to host |
| ack_n | output | 1 | Acknowledge pulse to host, active low |
| cfg_ack_len | input | ACKW | ACK pulse length in cycles (0 means 1) |
| cfg_busy_early | input | 1 | 1: BUSY drops as ACK starts; 0: BUSY drops after ACK |
| ctl_table | input | 10*ENTRIES | Control-character table entries |
| max_len | input | LENW | Maximum bytes per receive buffer |
| buf_ready | input | 1 | Current receive buffer is ready |
| wr_en | output | 1 | Buffer write strobe |
| wr_data | output | 8 | Byte written |
| wr_count | output | LENW | Bytes in buffer including this write |
| buf_close | output | 1 | Buffer closed with this write |
| rccr | output | 8 | Last rejected control character |
| ev_ctl | output | 1 | Control character rejected event |
| ev_buf | output | 1 | Buffer done event |
| ev_busy | output | 1 | Byte arrived with no ready buffer |
| irq_en | input | 3 | Event interrupt enables |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with LENW=4 and ACKW=3, and keeps eight table entries. A max_len of 5 can then be reached inside short streams, so closes by length can be tested next to closes by matched character. ACK lengths of 0, 2 and 6 fit in the narrow field, which covers the zero-length rule and both BUSY placements. The eight-entry table holds a disabled entry and a shadowed duplicate character, so the lowest-valid-index priority is exercised as well as plain matching.

// File: rtl/parport_rx_pkg.sv
package parport_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_STORE = 2'd2,
        ST_ACK   = 2'd3
    } rx_state_e;

    localparam int ENTRY_W  = 10;
    localparam int CHAR_W   = 8;
    localparam int REJ_BIT  = 8;
    localparam int VAL_BIT  = 9;
endpackage

// File: rtl/parport_rx_sync.sv
module parport_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '1;
        end else begin
            sh <= {sh[STAGES-1:0], strobe_n};
        end
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/parport_rx_match.sv
module parport_rx_match
    import parport_rx_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES*ENTRY_W-1:0] table_i,
    input  logic [CHAR_W-1:0]          byte_i,
    output logic                       hit,
    output logic                       rej
);
    logic [ENTRIES-1:0] hits;
    logic [ENTRIES-1:0] rejs;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign hits[i] = table_i[ENTRY_W*i + VAL_BIT] &&
                         (table_i[ENTRY_W*i +: CHAR_W] == byte_i);
        assign rejs[i] = table_i[ENTRY_W*i + REJ_BIT];
    end

    // lowest index wins: scan downward so the last assignment is the lowest hit
    always_comb begin
        hit = 1'b0;
        rej = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                hit = 1'b1;
                rej = rejs[i];
            end
        end
    end
endmodule

// File: rtl/parport_rx_fill.sv
module parport_rx_fill #(
    parameter int LENW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act,
    input  logic [7:0]      byte_i,
    input  logic            hit,
    input  logic            rej,
    input  logic [LENW-1:0] max_len,
    output logic            wr_en,
    output logic [7:0]      wr_data,
    output logic [LENW-1:0] wr_count,
    output logic            buf_close,
    output logic [7:0]      rccr,
    output logic            ev_ctl,
    output logic            ev_buf
);
    localparam logic [LENW-1:0] ONE = {{(LENW-1){1'b0}}, 1'b1};

    logic [LENW-1:0] cnt;
    logic [LENW-1:0] next_cnt;
    logic            len_full;

    assign next_cnt = cnt + ONE;
    assign len_full = (next_cnt == max_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            wr_count  <= '0;
            buf_close <= 1'b0;
            rccr      <= '0;
            ev_ctl    <= 1'b0;
            ev_buf    <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            buf_close <= 1'b0;
            ev_ctl    <= 1'b0;
            ev_buf    <= 1'b0;
            if (act) begin
                if (hit && rej) begin
                    rccr   <= byte_i;
                    ev_ctl <= 1'b1;
                end else begin
                    wr_en    <= 1'b1;
                    wr_data  <= byte_i;
                    wr_count <= next_cnt;
                    if (hit || len_full) begin
                        buf_close <= 1'b1;
                        ev_buf    <= 1'b1;
                        cnt       <= '0;
                    end else begin
                        cnt <= next_cnt;
                    end
                end
            end
        end
    end

    AST_CLOSE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close |-> wr_en); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && max_len != '0) |-> (wr_count <= max_len)); // R9
    AST_REJ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ctl |-> !wr_en); // R8
    AST_EVT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buf == buf_close); // R10
endmodule

// File: rtl/parport_rx.sv
module parport_rx
    import parport_rx_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LENW    = 8,
    parameter int ACKW    = 4,
    parameter int SYNC    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe_n,
    input  logic [7:0]                 data_in,
    output logic                       busy,
    output logic                       ack_n,
    input  logic [ACKW-1:0]            cfg_ack_len,
    input  logic                       cfg_busy_early,
    input  logic [ENTRIES*ENTRY_W-1:0] ctl_table,
    input  logic [LENW-1:0]            max_len,
    input  logic                       buf_ready,
    output logic                       wr_en,
    output logic [7:0]                 wr_data,
    output logic [LENW-1:0]            wr_count,
    output logic                       buf_close,
    output logic [7:0]                 rccr,
    output logic                       ev_ctl,
    output logic                       ev_buf,
    output logic                       ev_busy,
    input  logic [2:0]                 irq_en,
    output logic                       irq
);
    localparam logic [ACKW-1:0] ACK_ONE = {{(ACKW-1){1'b0}}, 1'b1};

    rx_state_e       state, state_nx;
    logic            fall;
    logic [7:0]      byte_q;
    logic [ACKW-1:0] ack_cnt;
    logic            hit, rej;
    logic            store_act;

    parport_rx_sync #(.STAGES(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .fall     (fall)
    );

    parport_rx_match #(.ENTRIES(ENTRIES)) u_match (
        .table_i (ctl_table),
        .byte_i  (byte_q),
        .hit     (hit),
        .rej     (rej)
    );

    parport_rx_fill #(.LENW(LENW)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (store_act),
        .byte_i    (byte_q),
        .hit       (hit),
        .rej       (rej),
        .max_len   (max_len),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_count  (wr_count),
        .buf_close (buf_close),
        .rccr      (rccr),
        .ev_ctl    (ev_ctl),
        .ev_buf    (ev_buf)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fall) state_nx = buf_ready ? ST_STORE : ST_STALL;
            ST_STALL: if (buf_ready) state_nx = ST_STORE;
            ST_STORE: state_nx = ST_ACK;
            ST_ACK:   if (ack_cnt == ACK_ONE) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // byte latch, ACK timer, stall event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q  <= '0;
            ack_cnt <= '0;
            ev_busy <= 1'b0;
        end else begin
            ev_busy <= 1'b0;
            if (state == ST_IDLE && fall) begin
                byte_q  <= data_in;
                ev_busy <= !buf_ready;
            end
            if (state == ST_STORE) begin
                ack_cnt <= (cfg_ack_len == '0) ? ACK_ONE : cfg_ack_len;
            end else if (state == ST_ACK) begin
                ack_cnt <= ack_cnt - ACK_ONE;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        ack_n     = 1'b1;
        store_act = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_STALL: busy = 1'b1;
            ST_STORE: begin
                busy      = 1'b1;
                store_act = 1'b1;
            end
            ST_ACK: begin
                busy  = !cfg_busy_early;
                ack_n = 1'b0;
            end
            default: busy = 1'b0;
        endcase
    end

    assign irq = |(irq_en & {ev_busy, ev_ctl, ev_buf});

    AST_ACK_BUSY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !cfg_busy_early) |-> busy); // R4
    AST_ACK_BUSY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && cfg_busy_early) |-> !busy); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |-> (busy && ack_n && !wr_en)); // R11
    AST_ACK_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> (wr_en || ev_ctl)); // R3
    AST_STALL_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busy |-> (state == ST_STALL)); // R11
endmodule

// File: tb/parport_rx_bench.sv
module parport_rx_bench;
    localparam int ENTRIES = 8;
    localparam int LENW    = 4;
    localparam int ACKW    = 3;
    localparam int IW      = LENW + 11;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   strobe_n = 1'b1;
    logic [7:0]             data_in = '0;
    logic                   busy, ack_n;
    logic [ACKW-1:0]        cfg_ack_len = 3'd2;
    logic                   cfg_busy_early = 1'b0;
    logic [ENTRIES*10-1:0]  ctl_table = '0;
    logic [LENW-1:0]        max_len = 4'd5;
    logic                   buf_ready = 1'b1;
    logic                   wr_en, buf_close, ev_ctl, ev_buf, ev_busy, irq;
    logic [7:0]             wr_data, rccr;
    logic [LENW-1:0]        wr_count;
    logic [2:0]             irq_en = 3'b111;

    int total = 0;
    int bad = 0;
    int mcnt = 0;
    int exp_rej = 0, seen_rej = 0;
    int exp_irq = 0, seen_irq = 0;
    int seen_bsy = 0;
    // item: {matched, rej, close, count, data}
    logic [IW-1:0] q[$];

    always #2.5 clk = ~clk;

    parport_rx #(.ENTRIES(ENTRIES), .LENW(LENW), .ACKW(ACKW)) u_parport_rx (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .data_in(data_in),
        .busy(busy), .ack_n(ack_n), .cfg_ack_len(cfg_ack_len),
        .cfg_busy_early(cfg_busy_early), .ctl_table(ctl_table),
        .max_len(max_len), .buf_ready(buf_ready), .wr_en(wr_en),
        .wr_data(wr_data), .wr_count(wr_count), .buf_close(buf_close),
        .rccr(rccr), .ev_ctl(ev_ctl), .ev_buf(ev_buf), .ev_busy(ev_busy),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_entry(input int i, input bit v, input bit r, input logic [7:0] c);
        ctl_table[10*i +: 10] = {v, r, c};
    endtask

    function automatic logic [1:0] lookup(input logic [7:0] b);
        for (int i = 0; i < ENTRIES; i++)
            if (ctl_table[10*i+9] && ctl_table[10*i +: 8] == b)
                return {1'b1, ctl_table[10*i+8]};
        return 2'b00;
    endfunction

    // driver: push expectation, run one full handshake, check timing
    task automatic send_byte(input logic [7:0] b);
        logic [1:0] m;
        bit cl;
        int ac, lat;
        bit seen, bbad;
        m = lookup(b);
        if (m == 2'b11) begin
            q.push_back({1'b1, 1'b1, 1'b0, {LENW{1'b0}}, b});
            exp_rej++;
            if (irq_en[1]) exp_irq++;
        end else begin
            mcnt++;
            cl = m[1] || (mcnt == int'(max_len));
            q.push_back({m[1], 1'b0, cl, LENW'(mcnt), b});
            if (cl) begin
                mcnt = 0;
                if (irq_en[0]) exp_irq++;
            end
        end
        data_in  = b;
        strobe_n = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!busy);
        chk(lat == 3, "R2", "strobe-to-busy cycles", lat, 3);
        strobe_n = 1'b1;
        ac = 0; seen = 0; bbad = 0;
        forever begin
            @(negedge clk);
            if (!ack_n) begin
                ac++; seen = 1;
                if (busy !== !cfg_busy_early) bbad = 1;
            end else if (seen && !busy) break;
        end
        chk(ac == ((cfg_ack_len == 0) ? 1 : int'(cfg_ack_len)), "R3", "ack width",
            ac, (cfg_ack_len == 0) ? 1 : int'(cfg_ack_len));
        chk(!bbad, "R4", "busy placement during ack", bbad, 0);
    endtask

    // monitor: pop and compare scoreboard items
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) seen_irq++;
            if (ev_busy) seen_bsy++;
            if (wr_en || ev_ctl) begin
                if (q.size() == 0) begin
                    chk(0, "R6", "unexpected output", 1, 0);
                end else begin
                    logic [IW-1:0] it;
                    it = q.pop_front();
                    if (it[LENW+9]) begin
                        seen_rej++;
                        chk(ev_ctl && !wr_en, "R8", "reject without write", wr_en, 0);
                        chk(rccr == it[7:0], "R8", "rccr value", rccr, it[7:0]);
                    end else begin
                        string tg;
                        tg = !it[LENW+8] ? "R6" : (it[LENW+10] ? "R7" : "R9");
                        chk(wr_en && wr_data == it[7:0], tg, "wr_data", wr_data, it[7:0]);
                        chk(wr_count == it[LENW+7:8], tg, "wr_count", wr_count, it[LENW+7:8]);
                        chk(buf_close == it[LENW+8], tg, "buf_close", buf_close, it[LENW+8]);
                        chk(ev_buf == it[LENW+8], "R10", "ev_buf with close", ev_buf, it[LENW+8]);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        bit stall_ack, stall_busy_low;
        // R5 table: 0x0D store-close at 0, disabled 0x41 at 1, 0x1B reject at 2,
        // shadowed 0x0D reject at 3, 0x7E store-close at 7
        set_entry(0, 1, 0, 8'h0D);
        set_entry(1, 0, 1, 8'h41);
        set_entry(2, 1, 1, 8'h1B);
        set_entry(3, 1, 1, 8'h0D);
        set_entry(7, 1, 0, 8'h7E);
        repeat (3) @(negedge clk);
        chk(busy == 0 && ack_n == 1, "R1", "busy/ack after reset", {busy, ack_n}, 1);
        chk(!wr_en && !buf_close && !ev_ctl && !ev_buf && !ev_busy && !irq,
            "R1", "pulses after reset", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R8 R7 R5: plain, disabled entry, reject, plain, shadowed close
        send_byte(8'h10);
        send_byte(8'h41);
        send_byte(8'h1B);
        send_byte(8'h20);
        send_byte(8'h0D);
        // R9 length close after five, stream spans buffers
        for (int i = 1; i <= 6; i++) send_byte(8'(i));
        // R7 close through the last table entry
        send_byte(8'h7E);

        // R3 zero length, R4 early mode
        cfg_ack_len = 3'd0;
        cfg_busy_early = 1'b1;
        send_byte(8'h55);
        cfg_ack_len = 3'd6;
        send_byte(8'h1B);
        cfg_busy_early = 1'b0;
        send_byte(8'h56);

        // R11 stall
        buf_ready = 1'b0;
        stall_ack = 0; stall_busy_low = 0;
        if (irq_en[2]) exp_irq++;
        fork
            send_byte(8'h0D);
            begin
                repeat (25) begin
                    @(negedge clk);
                    if (!ack_n) stall_ack = 1;
                end
                repeat (20) begin
                    @(negedge clk);
                    if (!busy || !ack_n) stall_busy_low = 1;
                end
                buf_ready = 1'b1;
            end
        join
        chk(!stall_ack && !stall_busy_low, "R11", "busy held/no ack while stalled",
            stall_ack, 0);
        chk(seen_bsy == 1, "R11", "stall events", seen_bsy, 1);

        // R12 masking: only reject events enabled
        irq_en = 3'b010;
        send_byte(8'h1B);
        send_byte(8'h7E);
        repeat (4) @(negedge clk);
        chk(seen_irq == exp_irq, "R12", "irq pulses", seen_irq, exp_irq);
        chk(seen_rej == exp_rej, "R5", "reject events", seen_rej, exp_rej);
        chk(q.size() == 0, "R6", "scoreboard drained", q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule